// File: doc/BRIEF.md
# Fracturable Four-Input Logic Cell

This block is a single configurable logic cell of the kind tiled across a programmable fabric. At its core is a 16-entry truth table addressed by a 4-bit data input. The table can act as one 4-input function. It can also be split into two 3-input functions that both read the three low inputs. Two cell outputs follow. Each one can come straight from the table logic or from a flip-flop behind it.

The two flip-flops have other uses too. They can be chained into a two-stage shift register fed from a dedicated serial input. When scan is enabled, they form a two-bit test path from a scan input to a scan output. All behaviour is fixed by a static configuration word applied in parallel. That word holds the table contents and five select bits.

Top module: `flut_cell`

## Requirements
- R1: With select bit 16 set (whole-table mode), combinational output 0 equals table bit `cfg[din]`, where `din[3]` is the most significant index bit.
- R2: With select bit 16 clear (split mode), combinational output 0 equals table bit `cfg[din[2:0]]` (lower half, bits 7:0), and `din[3]` has no effect on it.
- R3: Combinational output 1 always equals table bit `cfg[8 + din[2:0]]` (upper half, bits 15:8), and `din[3]` has no effect on it.
- R4: When select bit 19 (bit 20) is set, `dout[0]` (`dout[1]`) shows flip-flop 0 (1), which holds the combinational output 0 (1) of the previous cycle, provided scan is off and the flip-flop's alternate source is not selected.
- R5: With select bit 17 set and scan off, flip-flop 0 captures `shift_in` instead of combinational output 0.
- R6: With select bit 18 set and scan off, flip-flop 1 captures flip-flop 0, so a bit on `shift_in` reaches `shift_out` two clocks later when R5 is also selected.
- R7: While `scan_en` is high, flip-flop 0 captures `scan_in` and flip-flop 1 captures flip-flop 0, regardless of every select bit.
- R8: A low `rst_n` clears both flip-flops at once, without waiting for a clock edge, so every registered output, `shift_out` and `scan_out` read 0.
- R9: `shift_out` and `scan_out` both carry flip-flop 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 4 | Table address inputs; bit 3 is the most significant |
| shift_in | input | 1 | Serial input of the shift chain |
| scan_in | input | 1 | Serial input of the scan path |
| scan_en | input | 1 | Selects the scan path for both flip-flops |
| cfg | input | 21 | Bits 15:0 hold the table. Bit 16 selects whole-table mode for output 0. Bit 17 sets the shift source for flip-flop 0. Bit 18 sets the chain source for flip-flop 1. Bits 19 and 20 register outputs 0 and 1 |
| dout | output | 2 | Cell outputs |
| shift_out | output | 1 | Serial output of the shift chain |
| scan_out | output | 1 | Serial output of the scan path |

## Verification
The hardest case to reach from the ports is a fault in the flip-flop source priority. Scan must win over the shift and chain selects. This shows only when scan is raised while those selects are also set and the serial inputs carry values that differ from the table outputs. The stimulus therefore turns on scan with every alternate source selected and different random bits on `scan_in`, `shift_in` and `din`. Split mode is checked by sweeping all sixteen addresses against a table whose halves disagree with the full-table view. Any leak of `din[3]` then shows up on an output.

// File: rtl/flut_pkg.sv
package flut_pkg;
  // Select bits of the configuration word, placed above the table contents.
  // The last field declared is the least significant bit.
  typedef struct packed {
    logic out1_reg;        // dout[1] taken from flip-flop 1
    logic out0_reg;        // dout[0] taken from flip-flop 0
    logic ff1_from_chain;  // flip-flop 1 loads flip-flop 0
    logic ff0_from_shift;  // flip-flop 0 loads shift_in
    logic out0_full;       // output 0 uses the whole table
  } flut_sel_t;

  localparam int SEL_W = $bits(flut_sel_t);
endpackage

// File: rtl/flut_table.sv
module flut_table #(
  parameter  int K      = 4,
  localparam int MASK_W = 1 << K
) (
  input  logic [K-1:0]      din,
  input  logic [MASK_W-1:0] mask,
  output logic              f_full,
  output logic              f_lo,
  output logic              f_hi
);
  // Each half is read by forcing the top index bit, so din[K-1] cannot reach it.
  logic [K-1:0] idx_lo;
  logic [K-1:0] idx_hi;

  always_comb begin
    idx_lo = {1'b0, din[K-2:0]};
    idx_hi = {1'b1, din[K-2:0]};
    f_full = mask[din];
    f_lo   = mask[idx_lo];
    f_hi   = mask[idx_hi];
  end

  // The full-table read and the lower-half read have to agree whenever the top input is low.
  always_comb begin
    if (din[K-1] == 1'b0) begin
      // R2
      split_lo_agree_chk: assert (f_full == f_lo);
    end
  end
endmodule

// File: rtl/flut_regpair.sv
module flut_regpair (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scan_en,
  input  logic       scan_in,
  input  logic       shift_in,
  input  logic [1:0] comb,
  input  logic       ff0_from_shift,
  input  logic       ff1_from_chain,
  output logic [1:0] q
);
  logic [1:0] q_next;

  // Next-state selection: scan first, then the alternate source, then the table output.
  always_comb begin
    if (scan_en) begin
      q_next[0] = scan_in;
      q_next[1] = q[0];
    end else begin
      q_next[0] = ff0_from_shift ? shift_in : comb[0];
      q_next[1] = ff1_from_chain ? q[0]     : comb[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_next;
    end
  end

  // R7
  scan_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> q[0] == $past(scan_in));

  // R7
  scan_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> q[1] == $past(q[0]));

  // R5
  shift_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && ff0_from_shift) |=> q[0] == $past(shift_in));

  // R6
  shift_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && ff1_from_chain) |=> q[1] == $past(q[0]));
endmodule

// File: rtl/flut_outsel.sv
module flut_outsel (
  input  logic       f_full,
  input  logic       f_lo,
  input  logic       f_hi,
  input  logic       out0_full,
  input  logic [1:0] reg_sel,
  input  logic [1:0] q,
  output logic [1:0] comb,
  output logic [1:0] dout
);
  always_comb begin
    comb[0] = out0_full ? f_full : f_lo;
    comb[1] = f_hi;
  end

  for (genvar b = 0; b < 2; b++) begin : g_out
    assign dout[b] = reg_sel[b] ? q[b] : comb[b];
  end
endmodule

// File: rtl/flut_cell.sv
module flut_cell
  import flut_pkg::*;
#(
  parameter  int K      = 4,
  localparam int MASK_W = 1 << K,
  localparam int CFG_W  = MASK_W + SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [K-1:0]     din,
  input  logic             shift_in,
  input  logic             scan_in,
  input  logic             scan_en,
  input  logic [CFG_W-1:0] cfg,
  output logic [1:0]       dout,
  output logic             shift_out,
  output logic             scan_out
);
  flut_sel_t         sel;
  logic [MASK_W-1:0] mask;
  logic              f_full;
  logic              f_lo;
  logic              f_hi;
  logic [1:0]        comb;
  logic [1:0]        q;

  assign mask = cfg[MASK_W-1:0];
  assign sel  = flut_sel_t'(cfg[CFG_W-1:MASK_W]);

  flut_table #(.K(K)) u_table (
    .din    (din),
    .mask   (mask),
    .f_full (f_full),
    .f_lo   (f_lo),
    .f_hi   (f_hi)
  );

  flut_outsel u_outsel (
    .f_full    (f_full),
    .f_lo      (f_lo),
    .f_hi      (f_hi),
    .out0_full (sel.out0_full),
    .reg_sel   ({sel.out1_reg, sel.out0_reg}),
    .q         (q),
    .comb      (comb),
    .dout      (dout)
  );

  flut_regpair u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .scan_en        (scan_en),
    .scan_in        (scan_in),
    .shift_in       (shift_in),
    .comb           (comb),
    .ff0_from_shift (sel.ff0_from_shift),
    .ff1_from_chain (sel.ff1_from_chain),
    .q              (q)
  );

  // R9: both serial outputs come from the second flip-flop
  assign shift_out = q[1];
  assign scan_out  = q[1];

  // R4
  reg_out0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !sel.ff0_from_shift) |=> (!sel.out0_reg || dout[0] == $past(comb[0])));

  // R4
  reg_out1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !sel.ff1_from_chain) |=> (!sel.out1_reg || dout[1] == $past(comb[1])));
endmodule

// File: tb/tb_flut_cell.sv
module tb_flut_cell;
  localparam int CFG_W = 21;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [3:0]       din;
  logic             shift_in;
  logic             scan_in;
  logic             scan_en;
  logic [CFG_W-1:0] cfg;
  logic [1:0]       dout;
  logic             shift_out;
  logic             scan_out;

  int total = 0;
  int bad   = 0;
  int m0    = 0;  // model of flip-flop 0
  int m1    = 0;  // model of flip-flop 1
  bit done  = 0;

  flut_cell dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .shift_in  (shift_in),
    .scan_in   (scan_in),
    .scan_en   (scan_en),
    .cfg       (cfg),
    .dout      (dout),
    .shift_out (shift_out),
    .scan_out  (scan_out)
  );

  always #10 clk = ~clk;

  function automatic int tbit(int idx);
    return int'(cfg[idx]);
  endfunction

  function automatic int model_c0();
    if (cfg[16]) return tbit(int'(din));
    return tbit(int'(din) % 8);
  endfunction

  function automatic int model_c1();
    return tbit(8 + int'(din) % 8);
  endfunction

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Inputs are set just after a falling edge; outputs are compared, then the model steps.
  task automatic cycle(string t0, string t1, string ts);
    int c0, c1, n0, n1;
    #2;
    c0 = model_c0();
    c1 = model_c1();
    check(t0, int'(dout[0]), cfg[19] ? m0 : c0);
    check(t1, int'(dout[1]), cfg[20] ? m1 : c1);
    check(ts, int'(shift_out), m1);
    check("R9 scan_out", int'(scan_out), m1);
    if (scan_en) begin
      n0 = int'(scan_in);
      n1 = m0;
    end else begin
      n0 = cfg[17] ? int'(shift_in) : c0;
      n1 = cfg[18] ? m0 : c1;
    end
    @(posedge clk);
    m0 = n0;
    m1 = n1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    din      = '0;
    shift_in = 1'b0;
    scan_in  = 1'b0;
    scan_en  = 1'b0;
    cfg      = {5'b11000, 16'hFFFF};
    repeat (3) @(negedge clk);
    #2;
    // R8 reset state
    check("R8 dout", int'(dout), 0);
    check("R8 shift_out", int'(shift_out), 0);
    check("R8 scan_out", int'(scan_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m0 = 0;
    m1 = 0;

    // R1 whole-table mode, every address
    cfg = {5'b00001, 16'hB16E};
    for (int i = 0; i < 16; i++) begin
      din = 4'(i);
      cycle("R1 dout0", "R3 dout1", "R9 shift_out");
    end

    // R2 / R3 split mode, every address; the halves differ from the full-table view
    cfg = {5'b00000, 16'h3C96};
    for (int i = 0; i < 16; i++) begin
      din = 4'(i);
      cycle("R2 dout0", "R3 dout1", "R9 shift_out");
    end

    // R4 registered outputs from the table
    cfg = {5'b11001, 16'h0000};
    for (int i = 0; i < 24; i++) begin
      cfg[15:0] = 16'($urandom);
      cfg[16]   = 1'($urandom);
      din       = 4'($urandom);
      cycle("R4 dout0", "R4 dout1", "R9 shift_out");
    end

    // R5 / R6 two-stage shift register
    cfg = {5'b11110, 16'h5AA5};
    for (int i = 0; i < 24; i++) begin
      din      = 4'($urandom);
      shift_in = 1'($urandom);
      cycle("R5 dout0", "R6 dout1", "R6 shift_out");
    end

    // R7 scan wins over every alternate source
    cfg = {5'b11111, 16'h9E37};
    scan_en = 1'b1;
    for (int i = 0; i < 24; i++) begin
      din      = 4'($urandom);
      shift_in = 1'($urandom);
      scan_in  = 1'($urandom);
      cycle("R7 dout0", "R7 dout1", "R7 shift_out");
    end
    cfg = {5'b11000, 16'hC3A1};
    for (int i = 0; i < 8; i++) begin
      din     = 4'($urandom);
      scan_in = 1'($urandom);
      cycle("R7 dout0", "R7 dout1", "R7 scan path");
    end

    // R8 reset in mid-run after loading ones
    scan_in = 1'b1;
    cycle("R7 dout0", "R7 dout1", "R7 scan path");
    cycle("R7 dout0", "R7 dout1", "R7 scan path");
    #3;
    rst_n = 1'b0;
    #2;
    check("R8 async dout", int'(dout), 0);
    check("R8 async shift_out", int'(shift_out), 0);
    check("R8 async scan_out", int'(scan_out), 0);
    m0 = 0;
    m1 = 0;
    @(negedge clk);
    rst_n   = 1'b1;
    scan_en = 1'b0;
    cfg     = {5'b11010, 16'h7E81};
    for (int i = 0; i < 6; i++) begin
      din      = 4'($urandom);
      shift_in = 1'($urandom);
      cycle("R5 dout0", "R4 dout1", "R9 shift_out");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule